// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the control side of a frame transmitter. It owns a small internal memory of buffer descriptors arranged as a ring. Each descriptor holds a 16-bit status word, a payload length and a buffer pointer. Software fills descriptors through a simple indexed read/write port and sets their ready bit. The engine then walks the ring in order. For every valid ready descriptor it presents one request to a downstream frame sender, carrying the pointer, the length, an end-of-frame flag and an append-checksum flag. When the sender acknowledges, the engine hands the descriptor back to software by clearing its ready bit.

The ring has no base or size configuration. A wrap bit in a descriptor's status sends the engine back to index 0. Past the last physical entry the engine also returns to 0. If the engine reaches a descriptor that is not ready, it parks on that index until software pulses a poll strobe. A graceful stop lets the current frame complete and then halts the engine with a sticky completion event. A soft reset command returns the engine to index 0 and keeps it busy for a fixed settling time, during which it takes no descriptor writes.

Top module: `tdr_engine`

## Requirements
- R1: After rst_ni, req_valid_o, rst_busy_o and events_o are all 0, and every descriptor field reads back as 0.
- R2: For a ready descriptor with a legal length, req_valid_o rises with req_ptr_o and req_len_o equal to the stored pointer and length, req_last_o equal to status bit 11 and req_crc_o equal to status bit 10. All of these stay stable until req_ack_i is sampled high.
- R3: On acknowledge, status bit 15 (ready) of that descriptor reads back 0, and every other status bit keeps its value.
- R4: Descriptors are served in index order. After a descriptor whose status bit 13 (wrap) is set, the next index is 0. After index NUM_DESC-1 the next index is also 0.
- R5: When the engine reaches a descriptor whose ready bit is 0, it issues no request, even if software later sets that bit, until poll_i is pulsed.
- R6: A ready descriptor with length 0 or above MAX_LEN (1500) gives no request. Its ready bit is cleared, events_o bit 1 is set, and the engine moves on to the next index. A length of 1 or of exactly 1500 is legal.
- R7: While stop_i is high, the engine still serves the remaining descriptors of a frame already started (a frame ends at a descriptor with bit 11 set). At the next frame boundary it issues no more requests and sets events_o bit 0.
- R8: While halted, ready descriptors are not served and stay ready. When stop_i drops, service resumes at the index where the engine halted, with no poll needed.
- R9: Each events_o bit stays set until a 1 is written to the same bit of ev_clr_i. A 0 in ev_clr_i leaves that bit unchanged.
- R10: A one-cycle soft_rst_i pulse clears events_o, returns the ring index to 0 and holds rst_busy_o high for exactly RST_CYCLES (16) cycles. Descriptor writes during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_we_i | input | 1 | Descriptor field write strobe |
| sw_idx_i | input | IDX_W | Descriptor index for read and write |
| sw_fld_i | input | 2 | Field select: 0 status, 1 length, 2 pointer, 3 reads 0 |
| sw_wdata_i | input | PTR_W | Write data (status and length use the low bits) |
| sw_rdata_o | output | PTR_W | Selected field, zero-extended |
| poll_i | input | 1 | Strobe: refetch a descriptor that was not ready |
| stop_i | input | 1 | Graceful stop request (level) |
| soft_rst_i | input | 1 | Soft reset command strobe |
| rst_busy_o | output | 1 | High while the soft reset settles |
| ev_clr_i | input | 2 | Write-one-to-clear for events_o |
| events_o | output | 2 | Sticky events: bit 0 stop done, bit 1 bad length |
| req_valid_o | output | 1 | Send request pending |
| req_ptr_o | output | PTR_W | Buffer pointer of the request |
| req_len_o | output | LEN_W | Payload length of the request |
| req_last_o | output | 1 | Request ends a frame |
| req_crc_o | output | 1 | Sender should append the checksum |
| req_ack_i | input | 1 | Sender accepts the pending request |

## Verification
A corrupted ring index shows up on the first request after it, as a pointer and length that belong to the wrong descriptor. It can also show up as a missing request, or as a ready bit that is left set when software reads it back once the batch is done. A wrong frame-boundary flag shows up only under graceful stop: the engine either halts mid-frame with a request left unserved, or serves a descriptor of the next frame before it raises the stop event. A stuck or lost event bit becomes visible at the next write-one-to-clear, or at the end of the batch where a bad length was skipped.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int STW      = 16;
  localparam int BIT_RDY  = 15;
  localparam int BIT_WRAP = 13;
  localparam int BIT_LAST = 11;
  localparam int BIT_CRC  = 10;

  localparam logic [1:0] FLD_STATUS = 2'd0;
  localparam logic [1:0] FLD_LEN    = 2'd1;
  localparam logic [1:0] FLD_PTR    = 2'd2;

  localparam int EV_STOP = 0;
  localparam int EV_LEN  = 1;
  localparam int NUM_EV  = 2;

  typedef enum logic [2:0] {
    ST_FETCH, ST_WAIT, ST_REQ, ST_HALT, ST_RST
  } seq_st_e;
endpackage

// File: rtl/tdr_desc_mem.sv
module tdr_desc_mem
  import tdr_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int PTR_W    = 32,
  parameter int LEN_W    = 16,
  localparam int IDX_W   = $clog2(NUM_DESC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [IDX_W-1:0] sw_idx_i,
  input  logic [1:0]       sw_fld_i,
  input  logic [PTR_W-1:0] sw_wdata_i,
  output logic [PTR_W-1:0] sw_rdata_o,
  input  logic [IDX_W-1:0] eng_idx_i,
  input  logic             clr_rdy_i,
  output logic [STW-1:0]   eng_status_o,
  output logic [LEN_W-1:0] eng_len_o,
  output logic [PTR_W-1:0] eng_ptr_o
);
  logic [NUM_DESC-1:0][STW-1:0]   status_q;
  logic [NUM_DESC-1:0][LEN_W-1:0] len_q;
  logic [NUM_DESC-1:0][PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      len_q    <= '0;
      ptr_q    <= '0;
    end else begin
      for (int i = 0; i < NUM_DESC; i++) begin
        if (sw_we_i && sw_idx_i == IDX_W'(i)) begin
          case (sw_fld_i)
            FLD_STATUS: status_q[i] <= sw_wdata_i[STW-1:0];
            FLD_LEN:    len_q[i]    <= sw_wdata_i[LEN_W-1:0];
            FLD_PTR:    ptr_q[i]    <= sw_wdata_i;
            default: ;
          endcase
        end
        // engine hand-back wins over a same-cycle software status write
        if (clr_rdy_i && eng_idx_i == IDX_W'(i)) status_q[i][BIT_RDY] <= 1'b0;
      end
    end
  end

  always_comb begin
    sw_rdata_o = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (sw_idx_i == IDX_W'(i)) begin
        case (sw_fld_i)
          FLD_STATUS: sw_rdata_o = PTR_W'(status_q[i]);
          FLD_LEN:    sw_rdata_o = PTR_W'(len_q[i]);
          FLD_PTR:    sw_rdata_o = ptr_q[i];
          default:    sw_rdata_o = '0;
        endcase
      end
    end
  end

  assign eng_status_o = status_q[eng_idx_i];
  assign eng_len_o    = len_q[eng_idx_i];
  assign eng_ptr_o    = ptr_q[eng_idx_i];

  AST_CLR_TAKES_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rdy_i |=> !status_q[$past(eng_idx_i)][BIT_RDY]) else $error("ready bit survived hand-back"); // R3
endmodule

// File: rtl/tdr_events.sv
module tdr_events #(
  parameter int N_EV = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            soft_rst_i,
  input  logic [N_EV-1:0] set_i,
  input  logic [N_EV-1:0] clr_i,
  output logic [N_EV-1:0] ev_o
);
  logic [N_EV-1:0] ev_q;

  for (genvar g = 0; g < N_EV; g++) begin : g_ev
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ev_q[g] <= 1'b0;
      else if (soft_rst_i)  ev_q[g] <= 1'b0;
      else if (set_i[g])    ev_q[g] <= 1'b1;
      else if (clr_i[g])    ev_q[g] <= 1'b0;
    end

    AST_EV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_q[g] && !clr_i[g] && !soft_rst_i) |=> ev_q[g]) else $error("event lost"); // R9
  end

  assign ev_o = ev_q;
endmodule

// File: rtl/tdr_seq.sv
module tdr_seq
  import tdr_pkg::*;
#(
  parameter int NUM_DESC   = 8,
  parameter int MAX_LEN    = 1500,
  parameter int RST_CYCLES = 16,
  parameter int PTR_W      = 32,
  parameter int LEN_W      = 16,
  localparam int IDX_W     = $clog2(NUM_DESC),
  localparam int CNT_W     = $clog2(RST_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             stop_i,
  input  logic             poll_i,
  input  logic             ack_i,
  input  logic             d_rdy_i,
  input  logic             d_wrap_i,
  input  logic             d_last_i,
  input  logic             d_crc_i,
  input  logic [LEN_W-1:0] d_len_i,
  input  logic [PTR_W-1:0] d_ptr_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             clr_rdy_o,
  output logic             busy_o,
  output logic             ev_stop_o,
  output logic             ev_len_o,
  output logic             req_valid_o,
  output logic [PTR_W-1:0] req_ptr_o,
  output logic [LEN_W-1:0] req_len_o,
  output logic             req_last_o,
  output logic             req_crc_o
);
  seq_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             in_frame_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] ptr_q;
  logic [LEN_W-1:0] len_q;
  logic             last_q, crc_q, wrap_q;

  logic len_bad, halt_now, skip;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i, input logic w);
    if (w || i == IDX_W'(NUM_DESC - 1)) return '0;
    return i + 1'b1;
  endfunction

  assign len_bad  = (d_len_i == '0) || (d_len_i > LEN_W'(MAX_LEN));
  assign halt_now = stop_i && !in_frame_q;
  assign skip     = !soft_rst_i && st_q == ST_FETCH && !halt_now && d_rdy_i && len_bad;

  assign ev_stop_o = !soft_rst_i && (st_q == ST_FETCH || st_q == ST_WAIT) && halt_now;
  assign ev_len_o  = skip;
  assign clr_rdy_o = skip || (!soft_rst_i && st_q == ST_REQ && ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_FETCH;
      idx_q      <= '0;
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      ptr_q      <= '0;
      len_q      <= '0;
      last_q     <= 1'b0;
      crc_q      <= 1'b0;
      wrap_q     <= 1'b0;
    end else if (soft_rst_i) begin
      st_q       <= ST_RST;
      cnt_q      <= '0;
      idx_q      <= '0;
      in_frame_q <= 1'b0;
    end else begin
      case (st_q)
        ST_FETCH: begin
          if (halt_now)       st_q <= ST_HALT;
          else if (!d_rdy_i)  st_q <= ST_WAIT;
          else if (len_bad) begin
            idx_q      <= step(idx_q, d_wrap_i);
            in_frame_q <= !d_last_i;
          end else begin
            ptr_q  <= d_ptr_i;
            len_q  <= d_len_i;
            last_q <= d_last_i;
            crc_q  <= d_crc_i;
            wrap_q <= d_wrap_i;
            st_q   <= ST_REQ;
          end
        end
        ST_WAIT: begin
          if (halt_now)    st_q <= ST_HALT;
          else if (poll_i) st_q <= ST_FETCH;
        end
        ST_REQ: begin
          if (ack_i) begin
            idx_q      <= step(idx_q, wrap_q);
            in_frame_q <= !last_q;
            st_q       <= ST_FETCH;
          end
        end
        ST_HALT: if (!stop_i) st_q <= ST_FETCH;
        ST_RST: begin
          if (cnt_q == CNT_W'(RST_CYCLES - 1)) st_q <= ST_FETCH;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_FETCH;
      endcase
    end
  end

  assign idx_o       = idx_q;
  assign busy_o      = st_q == ST_RST;
  assign req_valid_o = st_q == ST_REQ;
  assign req_ptr_o   = ptr_q;
  assign req_len_o   = len_q;
  assign req_last_o  = last_q;
  assign req_crc_o   = crc_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !ack_i && !soft_rst_i) |=> (req_valid_o && $stable(req_ptr_o) && $stable(req_len_o)
      && $stable(req_last_o) && $stable(req_crc_o))) else $error("request changed before ack"); // R2
  AST_REQ_LEN_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != '0 && req_len_o <= LEN_W'(MAX_LEN))) else $error("illegal length sent"); // R6
  AST_IDX_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(idx_q) < NUM_DESC) else $error("index outside ring"); // R4
endmodule

// File: rtl/tdr_engine.sv
module tdr_engine
  import tdr_pkg::*;
#(
  parameter int NUM_DESC   = 8,
  parameter int MAX_LEN    = 1500,
  parameter int RST_CYCLES = 16,
  parameter int PTR_W      = 32,
  parameter int LEN_W      = 16,
  localparam int IDX_W     = $clog2(NUM_DESC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [IDX_W-1:0] sw_idx_i,
  input  logic [1:0]       sw_fld_i,
  input  logic [PTR_W-1:0] sw_wdata_i,
  output logic [PTR_W-1:0] sw_rdata_o,
  input  logic             poll_i,
  input  logic             stop_i,
  input  logic             soft_rst_i,
  output logic             rst_busy_o,
  input  logic [1:0]       ev_clr_i,
  output logic [1:0]       events_o,
  output logic             req_valid_o,
  output logic [PTR_W-1:0] req_ptr_o,
  output logic [LEN_W-1:0] req_len_o,
  output logic             req_last_o,
  output logic             req_crc_o,
  input  logic             req_ack_i
);
  logic [IDX_W-1:0]  eng_idx;
  logic              clr_rdy, busy, ev_stop, ev_len;
  logic [STW-1:0]    eng_status;
  logic [LEN_W-1:0]  eng_len;
  logic [PTR_W-1:0]  eng_ptr;
  logic [NUM_EV-1:0] ev_set;

  tdr_desc_mem #(.NUM_DESC(NUM_DESC), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_mem (
    .clk_i, .rst_ni,
    .sw_we_i      (sw_we_i && !busy),
    .sw_idx_i, .sw_fld_i, .sw_wdata_i, .sw_rdata_o,
    .eng_idx_i    (eng_idx),
    .clr_rdy_i    (clr_rdy),
    .eng_status_o (eng_status),
    .eng_len_o    (eng_len),
    .eng_ptr_o    (eng_ptr)
  );

  tdr_seq #(.NUM_DESC(NUM_DESC), .MAX_LEN(MAX_LEN), .RST_CYCLES(RST_CYCLES),
            .PTR_W(PTR_W), .LEN_W(LEN_W)) u_seq (
    .clk_i, .rst_ni, .soft_rst_i, .stop_i, .poll_i,
    .ack_i       (req_ack_i),
    .d_rdy_i     (eng_status[BIT_RDY]),
    .d_wrap_i    (eng_status[BIT_WRAP]),
    .d_last_i    (eng_status[BIT_LAST]),
    .d_crc_i     (eng_status[BIT_CRC]),
    .d_len_i     (eng_len),
    .d_ptr_i     (eng_ptr),
    .idx_o       (eng_idx),
    .clr_rdy_o   (clr_rdy),
    .busy_o      (busy),
    .ev_stop_o   (ev_stop),
    .ev_len_o    (ev_len),
    .req_valid_o, .req_ptr_o, .req_len_o, .req_last_o, .req_crc_o
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_STOP] = ev_stop;
    ev_set[EV_LEN]  = ev_len;
  end

  tdr_events #(.N_EV(NUM_EV)) u_ev (
    .clk_i, .rst_ni, .soft_rst_i,
    .set_i (ev_set),
    .clr_i (ev_clr_i),
    .ev_o  (events_o)
  );

  assign rst_busy_o = busy;

  AST_BUSY_EV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_busy_o |-> events_o == '0) else $error("event set during soft reset"); // R10
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(events_o[EV_STOP]) |-> !req_valid_o) else $error("stop event with request pending"); // R7
endmodule

// File: tb/tdr_engine_tb.sv
module tdr_engine_tb;
  localparam int N = 8, MAXL = 1500, RSTC = 16, PW = 32, LW = 16, IW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sw_we = 0, poll = 0, stop = 0, soft_rst = 0, ack = 0;
  logic [IW-1:0] sw_idx = '0;
  logic [1:0] sw_fld = '0, ev_clr = '0, events;
  logic [PW-1:0] sw_wdata = '0, sw_rdata, req_ptr;
  logic [LW-1:0] req_len;
  logic busy, req_valid, req_last, req_crc;

  tdr_engine #(.NUM_DESC(N), .MAX_LEN(MAXL), .RST_CYCLES(RSTC), .PTR_W(PW), .LEN_W(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sw_we_i(sw_we), .sw_idx_i(sw_idx), .sw_fld_i(sw_fld),
    .sw_wdata_i(sw_wdata), .sw_rdata_o(sw_rdata), .poll_i(poll), .stop_i(stop),
    .soft_rst_i(soft_rst), .rst_busy_o(busy), .ev_clr_i(ev_clr), .events_o(events),
    .req_valid_o(req_valid), .req_ptr_o(req_ptr), .req_len_o(req_len),
    .req_last_o(req_last), .req_crc_o(req_crc), .req_ack_i(ack)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [LW-1:0] sh_len[N];
  logic [PW-1:0] sh_ptr[N];
  logic [15:0]   sh_st[N];
  bit            sh_wrap[N];
  int            exp_idx = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int i);
    return (sh_wrap[i] || i == N - 1) ? 0 : i + 1;
  endfunction

  function automatic logic [15:0] mk_st(input bit last, input bit crc, input bit wrap, input logic [9:0] low);
    return {1'b1, 1'b0, wrap, 1'b0, last, crc, low};
  endfunction

  function automatic bit len_ok(input logic [LW-1:0] l);
    return l != 0 && l <= MAXL;
  endfunction

  task automatic sw_write(input int i, input logic [1:0] f, input logic [PW-1:0] d);
    sw_we = 1; sw_idx = IW'(i); sw_fld = f; sw_wdata = d;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic sw_read(input int i, input logic [1:0] f, output logic [PW-1:0] d);
    sw_idx = IW'(i); sw_fld = f;
    #1 d = sw_rdata;
  endtask

  task automatic write_desc(input int i, input logic [15:0] st, input logic [LW-1:0] l, input logic [PW-1:0] p);
    sh_st[i] = st; sh_len[i] = l; sh_ptr[i] = p;
    sw_write(i, 2'd1, PW'(l));
    sw_write(i, 2'd2, p);
    sw_write(i, 2'd0, PW'(st));
  endtask

  task automatic do_poll();
    repeat (3) @(negedge clk);
    poll = 1;
    @(negedge clk);
    poll = 0;
  endtask

  task automatic wait_valid(output bit hit);
    hit = 0;
    for (int k = 0; k < 300; k++) begin
      if (req_valid) begin hit = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic expect_req(input int i, input string tag, input bit hold);
    bit hit;
    wait_valid(hit);
    chk(hit, {tag, " request seen"}, hit, 1);
    if (hit) begin
      chk(req_ptr == sh_ptr[i], {tag, " ptr"}, req_ptr, sh_ptr[i]);
      chk(req_len == sh_len[i], {tag, " len"}, req_len, sh_len[i]);
      chk({req_last, req_crc} == {sh_st[i][11], sh_st[i][10]}, {tag, " last/crc"},
          {req_last, req_crc}, {sh_st[i][11], sh_st[i][10]});
      if (hold) begin
        repeat (3) @(negedge clk);
        chk(req_valid && req_ptr == sh_ptr[i] && req_len == sh_len[i], "R2 held until ack",
            req_ptr, sh_ptr[i]);
      end
      ack = 1;
      @(negedge clk);
      ack = 0;
    end
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (req_valid) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic rand_batch();
    int n, p;
    int pos[4];
    bit okv[4];
    bit any_bad = 0;
    logic [PW-1:0] d;
    n = 1 + int'($urandom % 4);
    p = exp_idx;
    for (int j = 0; j < n; j++) begin
      logic [LW-1:0] l;
      int r = int'($urandom % 8);
      bit last = (j == n - 1) ? 1'b1 : 1'($urandom % 2);
      case (r)
        0: l = 0;
        1: l = LW'(MAXL + 1 + int'($urandom % 500));
        2: l = LW'(MAXL);
        3: l = 1;
        default: l = LW'(1 + int'($urandom % MAXL));
      endcase
      write_desc(p, mk_st(last, 1'($urandom % 2), sh_wrap[p], 10'($urandom)), l, $urandom);
      pos[j] = p; okv[j] = len_ok(l);
      p = nxt(p);
    end
    do_poll();
    for (int j = 0; j < n; j++) begin
      if (okv[j]) expect_req(pos[j], "R4 ring order", 0);
      else any_bad = 1;
    end
    exp_idx = p;
    expect_quiet(20, "R6 bad length not sent");
    for (int j = 0; j < n; j++) begin
      sw_read(pos[j], 2'd0, d);
      chk(d[15:0] == (sh_st[pos[j]] & 16'h7fff), "R3 ready cleared", d[15:0], sh_st[pos[j]] & 16'h7fff);
    end
    chk(events == {any_bad, 1'b0}, "R6 length event", events, {any_bad, 1'b0});
    ev_clr = 2'b11;
    @(negedge clk);
    ev_clr = 2'b00;
    chk(events == 2'b00, "R9 write one clears", events, 0);
  endtask

  initial begin
    logic [PW-1:0] d;
    bit hit;
    int cnt, a, b, c, e;
    void'($urandom(32'd7321));
    for (int i = 0; i < N; i++) begin sh_wrap[i] = 0; sh_st[i] = 0; sh_len[i] = 0; sh_ptr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk(!req_valid && !busy && events == 0, "R1 outputs after reset", {req_valid, busy, events}, 0);
    sw_read(0, 2'd0, d);
    chk(d == 0, "R1 descriptor reset", d, 0);

    // R2/R3/R5 directed
    write_desc(0, 16'h8C00, 16'd64, 32'h0000_1000);
    do_poll();
    expect_req(0, "R2 first descriptor", 1);
    repeat (2) @(negedge clk);
    sw_read(0, 2'd0, d);
    chk(d[15:0] == 16'h0C00, "R3 status after ack", d[15:0], 16'h0C00);
    repeat (3) @(negedge clk);
    write_desc(1, 16'h8800, 16'd200, 32'h0000_2000);
    expect_quiet(15, "R5 no fetch without poll");
    do_poll();
    expect_req(1, "R5 fetch after poll", 0);
    exp_idx = 2;

    // R4 wrap bit at index 5
    sh_wrap[5] = 1;
    for (int r = 0; r < 8; r++) rand_batch();
    // R4 natural wrap past last index
    sh_wrap[5] = 0;
    for (int r = 0; r < 10; r++) rand_batch();

    // R7/R8 graceful stop mid-frame
    a = exp_idx; b = nxt(a); c = nxt(b); e = nxt(c);
    write_desc(a, mk_st(0, 1, 0, 10'h011), 16'd100, 32'hA000_0000);
    write_desc(b, mk_st(0, 0, 0, 10'h022), 16'd200, 32'hB000_0000);
    write_desc(c, mk_st(1, 1, 0, 10'h033), 16'd300, 32'hC000_0000);
    write_desc(e, mk_st(1, 0, 0, 10'h044), 16'd400, 32'hD000_0000);
    do_poll();
    wait_valid(hit);
    stop = 1;
    expect_req(a, "R7 frame head", 0);
    expect_req(b, "R7 frame middle", 0);
    expect_req(c, "R7 frame tail", 0);
    expect_quiet(25, "R8 halted ignores ready");
    chk(events == 2'b01, "R7 stop event", events, 1);
    sw_read(e, 2'd0, d);
    chk(d[15], "R8 descriptor still ready", d[15], 1);
    stop = 0;
    expect_req(e, "R8 resume same index", 0);
    exp_idx = nxt(e);
    chk(events == 2'b01, "R9 event sticky", events, 1);
    ev_clr = 2'b10;
    @(negedge clk);
    ev_clr = 2'b00;
    chk(events == 2'b01, "R9 other bit untouched", events, 1);

    // R10 soft reset
    repeat (3) @(negedge clk);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    chk(events == 0, "R10 events cleared", events, 0);
    sw_we = 1; sw_idx = 0; sw_fld = 2'd1; sw_wdata = 32'h77;
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
      sw_we = 0;
    end
    sw_we = 0;
    chk(cnt == RSTC, "R10 busy length", cnt, RSTC);
    sw_read(0, 2'd1, d);
    chk(d[LW-1:0] == sh_len[0], "R10 write ignored while busy", d, sh_len[0]);
    write_desc(0, mk_st(1, 0, 0, 10'h055), 16'd1500, 32'hE000_0000);
    do_poll();
    expect_req(0, "R10 index back to 0", 0);

    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule